// File: doc/BRIEF.md
# Sequential-Access RGB Color Lookup Table

This block stores a 256-entry color lookup table. Each entry holds an 18-bit color made of three 6-bit channels: red, green and blue. The lookup runs in two directions. A host side reaches the table through four byte-wide registers, chosen by a 2-bit select: a write pointer, a read pointer, a data port and a pixel mask. A pixel side presents an 8-bit pixel code on every cycle and receives the matching color one cycle later.

The host never addresses a color channel directly. It sets a pointer and then walks the data port. Three data writes in a row fill one entry, red first, then green, then blue. Red and green wait in staging registers, and the entry changes only when the blue byte arrives. After that the write pointer moves to the next entry. Reads work the same way through their own pointer and their own channel step. A write to either pointer register restarts both channel sequences at red. The pixel mask is ANDed with every pixel code before the lookup, so software can limit which bits of the pixel reach the table.

Top module: `rgb_palette`

## Requirements
- R1: After reset both pointers read 0, the pixel mask reads 8'hFF, both channel sequences stand at red and every entry holds 18'h0.
- R2: Three data-port writes (hostSel=2) load the entry at the write pointer as {red[17:12], green[11:6], blue[5:0]}, taken from bits [5:0] of the first, second and third byte. Bits [7:6] are dropped.
- R3: The write pointer advances by one after each blue byte and wraps from 255 to 0.
- R4: A table entry keeps its old value after the red and green bytes and changes only when the blue byte is written.
- R5: Three data-port reads return red, then green, then blue of the entry at the read pointer, each in bits [5:0] with bits [7:6] zero. The read pointer then advances by one and wraps from 255 to 0.
- R6: Data reads never move the write pointer, and data writes never move the read pointer.
- R7: A write to the write-pointer register (hostSel=0) or the read-pointer register (hostSel=1) loads that pointer and returns both channel sequences to red.
- R8: pixColor shows the entry at (pixIn AND mask), registered, one clock after pixIn is sampled.
- R9: A write with hostSel=3 loads the pixel mask, and a read with hostSel=3 returns it.
- R10: Reads with hostSel=0 or hostSel=1 return the current write or read pointer and have no side effect.
- R11: When hostWr and hostRd are high in the same cycle, only the write takes effect. The read sequence and the read pointer stay unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWr | input | 1 | Host write strobe, one access per cycle |
| hostRd | input | 1 | Host read strobe, one access per cycle |
| hostSel | input | 2 | 0 write pointer, 1 read pointer, 2 data port, 3 pixel mask |
| hostWdata | input | 8 | Host write byte |
| hostRdata | output | 8 | Host read byte, combinational from hostSel and state |
| pixIn | input | 8 | Pixel code |
| pixColor | output | 18 | Registered color {red, green, blue} |

## Verification
The hardest case to reach is a data sequence that is cut off partway. This covers a pointer write that lands between red and blue, and a read strobe that collides with a write. In both cases the visible effect shows up only in the bytes that come later. Directed sequences therefore break off a write after the red byte, or a read after one channel, and then reload a pointer. The bench then checks that the next three bytes are again treated as red, green and blue. A partial write is also looked up through the pixel port before the blue byte, to show that the entry has not changed yet. Random traffic after these sequences mixes pointer loads, full triples, mask changes and pixel lookups, and a bench model of the table and both sequences follows every access.

// File: rtl/rgb_palette_pkg.sv
package rgb_palette_pkg;

  // host register select codes
  localparam logic [1:0] SEL_WIDX = 2'd0;
  localparam logic [1:0] SEL_RIDX = 2'd1;
  localparam logic [1:0] SEL_DATA = 2'd2;
  localparam logic [1:0] SEL_MASK = 2'd3;

  typedef enum logic [1:0] {
    PH_RED   = 2'd0,
    PH_GREEN = 2'd1,
    PH_BLUE  = 2'd2
  } phase_e;

  // control-to-datapath strobes
  typedef struct packed {
    logic loadRed;
    logic loadGreen;
    logic commit;
    logic loadMask;
  } pal_strobe_t;

  function automatic phase_e stepPhase(phase_e cur);
    case (cur)
      PH_RED:   stepPhase = PH_GREEN;
      PH_GREEN: stepPhase = PH_BLUE;
      default:  stepPhase = PH_RED;
    endcase
  endfunction

endpackage

// File: rtl/palette_ctrl.sv
module palette_ctrl
  import rgb_palette_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hostWr,
  input  logic             hostRd,
  input  logic [1:0]       hostSel,
  input  logic [IDX_W-1:0] idxData,
  output pal_strobe_t      strobe,
  output logic [IDX_W-1:0] writeIdx,
  output logic [IDX_W-1:0] readIdx,
  output phase_e           readPhase
);

  phase_e writePhase;
  logic   rdAccess;
  logic   addrWr;
  logic   dataWr;
  logic   dataRd;

  // a write in the same cycle wins over a read
  assign rdAccess = hostRd & ~hostWr;
  assign addrWr   = hostWr & ((hostSel == SEL_WIDX) | (hostSel == SEL_RIDX));
  assign dataWr   = hostWr & (hostSel == SEL_DATA);
  assign dataRd   = rdAccess & (hostSel == SEL_DATA);

  always_comb begin
    strobe.loadRed   = dataWr & (writePhase == PH_RED);
    strobe.loadGreen = dataWr & (writePhase == PH_GREEN);
    strobe.commit    = dataWr & (writePhase == PH_BLUE);
    strobe.loadMask  = hostWr & (hostSel == SEL_MASK);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      writePhase <= PH_RED;
      readPhase  <= PH_RED;
      writeIdx   <= '0;
      readIdx    <= '0;
    end else begin
      if (addrWr) begin
        writePhase <= PH_RED;
        readPhase  <= PH_RED;
        if (hostSel == SEL_WIDX) writeIdx <= idxData;
        else                     readIdx  <= idxData;
      end else begin
        if (dataWr) begin
          writePhase <= stepPhase(writePhase);
          if (writePhase == PH_BLUE) writeIdx <= writeIdx + 1'b1;
        end
        if (dataRd) begin
          readPhase <= stepPhase(readPhase);
          if (readPhase == PH_BLUE) readIdx <= readIdx + 1'b1;
        end
      end
    end
  end

  // R3: pointer steps by one after the blue byte
  a_r3_widx_step: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |=> writeIdx == $past(writeIdx) + 1'b1);

  // R5: read pointer steps after the third read
  a_r5_ridx_step: assert property (@(posedge clk) disable iff (!rstN)
    (dataRd && readPhase == PH_BLUE) |=> readIdx == $past(readIdx) + 1'b1);

  // R6: writes leave the read pointer alone
  a_r6_ridx_hold: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |=> $stable(readIdx));

  // R7: any pointer load restarts both sequences
  a_r7_seq_restart: assert property (@(posedge clk) disable iff (!rstN)
    addrWr |=> (writePhase == PH_RED && readPhase == PH_RED));

  // R11: colliding read is dropped
  a_r11_rd_blocked: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && hostRd && hostSel == SEL_DATA) |=> $stable(readPhase));

endmodule

// File: rtl/palette_dp.sv
module palette_dp
  import rgb_palette_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int CHAN_W = 6,
  parameter int HOST_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  pal_strobe_t         strobe,
  input  logic [HOST_W-1:0]   hostWdata,
  input  logic [1:0]          hostSel,
  input  logic [IDX_W-1:0]    writeIdx,
  input  logic [IDX_W-1:0]    readIdx,
  input  phase_e              readPhase,
  input  logic [IDX_W-1:0]    pixIn,
  output logic [HOST_W-1:0]   hostRdata,
  output logic [3*CHAN_W-1:0] pixColor
);

  localparam int DEPTH   = 1 << IDX_W;
  localparam int COLOR_W = 3 * CHAN_W;
  localparam int PAD_W   = HOST_W - CHAN_W;
  localparam int IPAD_W  = HOST_W - IDX_W;

  logic [COLOR_W-1:0] table_q [DEPTH];
  logic [CHAN_W-1:0]  stageRed;
  logic [CHAN_W-1:0]  stageGreen;
  logic [IDX_W-1:0]   pixMask;
  logic [COLOR_W-1:0] readEntry;
  logic [CHAN_W-1:0]  readChan;

  // staging and mask registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stageRed   <= '0;
      stageGreen <= '0;
      pixMask    <= '1;
    end else begin
      if (strobe.loadRed)   stageRed   <= hostWdata[CHAN_W-1:0];
      if (strobe.loadGreen) stageGreen <= hostWdata[CHAN_W-1:0];
      if (strobe.loadMask)  pixMask    <= hostWdata[IDX_W-1:0];
    end
  end

  // table storage, written as a whole entry on the blue byte
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) table_q[i] <= '0;
    end else if (strobe.commit) begin
      table_q[writeIdx] <= {stageRed, stageGreen, hostWdata[CHAN_W-1:0]};
    end
  end

  // pixel-side lookup, one register stage
  always_ff @(posedge clk) begin
    if (!rstN) pixColor <= '0;
    else       pixColor <= table_q[pixIn & pixMask];
  end

  // host-side read mux
  assign readEntry = table_q[readIdx];

  always_comb begin
    case (readPhase)
      PH_RED:   readChan = readEntry[3*CHAN_W-1:2*CHAN_W];
      PH_GREEN: readChan = readEntry[2*CHAN_W-1:CHAN_W];
      default:  readChan = readEntry[CHAN_W-1:0];
    endcase
  end

  always_comb begin
    case (hostSel)
      SEL_WIDX: hostRdata = {{IPAD_W{1'b0}}, writeIdx};
      SEL_RIDX: hostRdata = {{IPAD_W{1'b0}}, readIdx};
      SEL_DATA: hostRdata = {{PAD_W{1'b0}}, readChan};
      default:  hostRdata = {{IPAD_W{1'b0}}, pixMask};
    endcase
  end

  // R2: staging red holds until the next red byte
  a_r2_stage_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadRed |=> $stable(stageRed));

  // R5: data reads carry zero in the top bits
  a_r5_top_zero: assert property (@(posedge clk) disable iff (!rstN)
    (hostSel == SEL_DATA) |-> (hostRdata[HOST_W-1:CHAN_W] == '0));

  // R9: mask takes the written byte
  a_r9_mask_load: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadMask |=> pixMask == $past(hostWdata[IDX_W-1:0]));

endmodule

// File: rtl/rgb_palette.sv
module rgb_palette
  import rgb_palette_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int CHAN_W = 6,
  parameter int HOST_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                hostWr,
  input  logic                hostRd,
  input  logic [1:0]          hostSel,
  input  logic [HOST_W-1:0]   hostWdata,
  output logic [HOST_W-1:0]   hostRdata,
  input  logic [IDX_W-1:0]    pixIn,
  output logic [3*CHAN_W-1:0] pixColor
);

  pal_strobe_t      strobe;
  logic [IDX_W-1:0] writeIdx;
  logic [IDX_W-1:0] readIdx;
  phase_e           readPhase;

  palette_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .hostWr    (hostWr),
    .hostRd    (hostRd),
    .hostSel   (hostSel),
    .idxData   (hostWdata[IDX_W-1:0]),
    .strobe    (strobe),
    .writeIdx  (writeIdx),
    .readIdx   (readIdx),
    .readPhase (readPhase)
  );

  palette_dp #(.IDX_W(IDX_W), .CHAN_W(CHAN_W), .HOST_W(HOST_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .hostWdata (hostWdata),
    .hostSel   (hostSel),
    .writeIdx  (writeIdx),
    .readIdx   (readIdx),
    .readPhase (readPhase),
    .pixIn     (pixIn),
    .hostRdata (hostRdata),
    .pixColor  (pixColor)
  );

endmodule

// File: tb/tb_rgb_palette.sv
module tb_rgb_palette;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWr = 1'b0;
  logic        hostRd = 1'b0;
  logic [1:0]  hostSel = 2'd0;
  logic [7:0]  hostWdata = 8'd0;
  logic [7:0]  hostRdata;
  logic [7:0]  pixIn = 8'd0;
  logic [17:0] pixColor;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // bench model
  logic [17:0] mMem [256];
  logic [7:0]  mW, mR, mMask;
  int          mWPh, mRPh;
  logic [5:0]  mStR, mStG;

  always #4 clk = ~clk;

  rgb_palette dut (
    .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostRd(hostRd),
    .hostSel(hostSel), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .pixIn(pixIn), .pixColor(pixColor)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int i = 0; i < 256; i++) mMem[i] = 18'h0;
    mW = 0; mR = 0; mMask = 8'hFF; mWPh = 0; mRPh = 0; mStR = 0; mStG = 0;
  endtask

  task automatic modelWrite(logic [1:0] sel, logic [7:0] d);
    case (sel)
      2'd0: begin mW = d; mWPh = 0; mRPh = 0; end
      2'd1: begin mR = d; mWPh = 0; mRPh = 0; end
      2'd2: begin
        if (mWPh == 0) begin mStR = d[5:0]; mWPh = 1; end
        else if (mWPh == 1) begin mStG = d[5:0]; mWPh = 2; end
        else begin mMem[mW] = {mStR, mStG, d[5:0]}; mW = mW + 8'd1; mWPh = 0; end
      end
      default: mMask = d;
    endcase
  endtask

  function automatic logic [7:0] expRead(logic [1:0] sel);
    case (sel)
      2'd0: return mW;
      2'd1: return mR;
      2'd2: begin
        if (mRPh == 0) return {2'b00, mMem[mR][17:12]};
        if (mRPh == 1) return {2'b00, mMem[mR][11:6]};
        return {2'b00, mMem[mR][5:0]};
      end
      default: return mMask;
    endcase
  endfunction

  task automatic hostWrite(logic [1:0] sel, logic [7:0] d);
    @(negedge clk);
    hostWr = 1'b1; hostSel = sel; hostWdata = d;
    @(posedge clk); #1;
    hostWr = 1'b0;
    modelWrite(sel, d);
  endtask

  // read with check against the model
  task automatic hostReadChk(string req, logic [1:0] sel);
    @(negedge clk);
    hostRd = 1'b1; hostSel = sel;
    #1 check(req, hostRdata, expRead(sel));
    @(posedge clk); #1;
    hostRd = 1'b0;
    if (sel == 2'd2) begin
      if (mRPh == 2) begin mRPh = 0; mR = mR + 8'd1; end
      else mRPh = mRPh + 1;
    end
  endtask

  task automatic hostReadVal(string req, logic [1:0] sel, logic [7:0] exp);
    check(req, expRead(sel), exp);
    hostReadChk(req, sel);
  endtask

  task automatic pixelChk(string req, logic [7:0] p);
    @(negedge clk);
    pixIn = p;
    @(posedge clk);
    @(negedge clk);
    check(req, pixColor, mMem[p & mMask]);
  endtask

  task automatic writeTriple(logic [7:0] r, logic [7:0] g, logic [7:0] b);
    hostWrite(2'd2, r); hostWrite(2'd2, g); hostWrite(2'd2, b);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    modelReset();
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1: reset state
    hostReadVal("R1 widx", 2'd0, 8'h00);
    hostReadVal("R1 ridx", 2'd1, 8'h00);
    hostReadVal("R1 mask", 2'd3, 8'hFF);
    pixelChk("R1 entry200", 8'd200);
    hostReadVal("R1 entry0 red", 2'd2, 8'h00);

    // R2, R5: full write and read triple with high bits dropped
    hostWrite(2'd0, 8'd5);
    writeTriple(8'hFF, 8'h41, 8'h2A);
    hostReadVal("R3 widx step", 2'd0, 8'd6);
    hostWrite(2'd1, 8'd5);
    hostReadVal("R2 R5 red", 2'd2, 8'h3F);
    hostReadVal("R2 R5 green", 2'd2, 8'h01);
    hostReadVal("R2 R5 blue", 2'd2, 8'h2A);
    hostReadVal("R5 ridx step", 2'd1, 8'd6);
    hostReadVal("R6 widx untouched by reads", 2'd0, 8'd6);

    // R4: partial write invisible until blue
    hostWrite(2'd2, 8'h15); hostWrite(2'd2, 8'h16);
    pixelChk("R4 before blue", 8'd6);
    check("R4 entry6 still zero", mMem[6], 18'h0);
    hostWrite(2'd2, 8'h17);
    pixelChk("R4 R8 after blue", 8'd6);
    hostReadVal("R6 ridx untouched by writes", 2'd1, 8'd6);

    // R3, R5: wrap
    hostWrite(2'd0, 8'd255);
    writeTriple(8'h01, 8'h02, 8'h03);
    hostReadVal("R3 widx wrap", 2'd0, 8'd0);
    hostWrite(2'd1, 8'd255);
    hostReadChk("R5 wrap red", 2'd2);
    hostReadChk("R5 wrap green", 2'd2);
    hostReadChk("R5 wrap blue", 2'd2);
    hostReadVal("R5 ridx wrap", 2'd1, 8'd0);

    // R7: pointer write restarts sequences
    hostWrite(2'd0, 8'd10);
    hostWrite(2'd2, 8'h11);
    hostWrite(2'd1, 8'd3);
    writeTriple(8'h22, 8'h33, 8'h04);
    check("R7 entry10", mMem[10], {6'h22, 6'h33, 6'h04});
    hostWrite(2'd1, 8'd10);
    hostReadChk("R7 red before restart", 2'd2);
    hostWrite(2'd0, 8'd20);
    hostReadVal("R7 red after restart", 2'd2, 8'h22);
    hostReadVal("R7 green", 2'd2, 8'h33);
    hostReadVal("R7 blue", 2'd2, 8'h04);

    // R11: write wins over simultaneous read
    hostWrite(2'd0, 8'd30);
    hostWrite(2'd1, 8'd10);
    @(negedge clk);
    hostWr = 1'b1; hostRd = 1'b1; hostSel = 2'd2; hostWdata = 8'h05;
    @(posedge clk); #1;
    hostWr = 1'b0; hostRd = 1'b0;
    modelWrite(2'd2, 8'h05);
    hostWrite(2'd2, 8'h06); hostWrite(2'd2, 8'h07);
    hostReadVal("R11 read seq held red", 2'd2, 8'h22);
    hostReadChk("R11 green", 2'd2);
    hostReadChk("R11 blue", 2'd2);
    hostReadVal("R11 ridx", 2'd1, 8'd11);
    check("R11 entry30", mMem[30], {6'h05, 6'h06, 6'h07});

    // R9, R8: mask
    hostWrite(2'd3, 8'h0F);
    hostReadVal("R9 mask readback", 2'd3, 8'h0F);
    pixelChk("R8 R9 masked lookup", 8'hF5);
    check("R8 masked target", mMem[8'hF5 & 8'h0F], {6'h3F, 6'h01, 6'h2A});
    hostReadVal("R10 widx", 2'd0, 8'd31);
    hostReadVal("R10 widx no side effect", 2'd0, 8'd31);

    // random traffic
    for (int n = 0; n < 300; n++) begin
      int op;
      op = $urandom % 8;
      if (op < 3) begin
        if (op == 0) hostWrite(2'd0, 8'($urandom));
        writeTriple(8'($urandom), 8'($urandom), 8'($urandom));
      end else if (op < 5) begin
        if (op == 3) hostWrite(2'd1, 8'($urandom));
        hostReadChk("R5 random red", 2'd2);
        hostReadChk("R5 random green", 2'd2);
        hostReadChk("R5 random blue", 2'd2);
      end else if (op == 5) begin
        pixelChk("R8 random lookup", 8'($urandom));
      end else if (op == 6) begin
        hostWrite(2'd3, 8'($urandom) | 8'hC0);
        hostReadChk("R9 random mask", 2'd3);
      end else begin
        hostReadChk("R10 random widx", 2'd0);
        hostReadChk("R10 random ridx", 2'd1);
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule